// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

This block decides which of several bus masters may drive a shared bus. Every master has a private request line and receives a private grant line. The masters share one release strobe, which the current owner pulses when its tenure is over. Exactly one grant is active at a time. The index of the owner is also given as a binary number.

The arbiter is centralized and works in parallel. A tenure begins when a requesting master is granted the bus, and it lasts until the release strobe. Requests from other masters do not shorten it. When the bus is free, the next owner is found by a rotating search. The search starts at the master just after the previous owner. This bounds the wait of every master, the lowest-priority one included.

When no master is requesting, the grant stays parked on the last owner. That master can then begin another transfer without arbitrating again. Another master takes a parked bus on the next clock edge, and no release is needed for that.

Top module: `park_bus_arbiter`

## Requirements
- R1: While rst_ni is low, and right after it, grant_o is all zero and owner_o is 0.
- R2: At every clock edge grant_o has at most one bit set. When a bit is set, owner_o holds its index.
- R3: When no tenure is active and at least one request is high at an edge, grant_o goes to one requesting master after that edge. That master is the first requester found by counting upward from the previous owner's index plus one, modulo N, with the previous owner checked last.
- R4: During a tenure, grant_o and owner_o stay unchanged whatever the request lines do, until release_i is sampled high.
- R5: When release_i is sampled high during a tenure, the next grant is chosen by the rule of R3 at that same edge. If no request is high, the grant stays on the same owner, and that owner is then parked.
- R6: A parked owner loses the bus at the first edge at which another master requests, and release_i is not required.
- R7: After reset, if no master requests at the first edge, the grant parks on master 0 (grant_o = 0001 for four masters).
- R8: When all masters request continuously and each tenure is released, ownership rotates through the indices in ascending order with wrap-around. No master waits for more than N-1 tenures.
- R9: A parked owner whose request rises while no other master requests keeps grant_o unchanged and begins a tenure, which R4 then protects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Request line for each master |
| release_i | input | 1 | Shared end-of-tenure strobe from the current owner |
| grant_o | output | N_MASTERS | One-hot grant, or all zero right after reset |
| owner_o | output | IDX_W | Index of the granted or parked master |

## Verification
The state that can go wrong inside is the tenure flag and the stored last owner, and either fault reaches the ports within one edge. If the tenure flag is lost, a competing request pulls the grant away in mid-tenure. If the flag is stuck, a parked bus never moves to a new requester. If the stored owner is corrupted, the rotation skips or repeats a master, and owner_o disagrees with grant_o. The bench drives directed sequences for parking, release and rotation, and then a pseudo-random sweep. It compares grant_o and owner_o after every edge with an arithmetic model of the rotation.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;
  typedef enum logic [1:0] {
    ARB_EMPTY  = 2'd0,  // after reset, nothing granted yet
    ARB_PARKED = 2'd1,  // grant held with no active tenure
    ARB_HELD   = 2'd2   // tenure active until release
  } arb_state_e;
endpackage

// File: rtl/park_rr_pick.sv
module park_rr_pick #(
  parameter int unsigned N_MASTERS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [IDX_W-1:0]     last_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  // descending scan so the nearest candidate after last_i wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = last_i;
    for (int k = N_MASTERS; k >= 1; k--) begin
      int cand;
      cand = int'(last_i) + k;
      if (cand >= int'(N_MASTERS)) cand = cand - int'(N_MASTERS);
      if (req_i[cand]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/park_tenure_ctl.sv
module park_tenure_ctl
  import park_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_req_i,
  input  logic       release_i,
  output logic       load_o,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;

  assign load_o = (state_q != ARB_HELD) || release_i;

  always_comb begin
    state_d = state_q;
    if (load_o) state_d = any_req_i ? ARB_HELD : ARB_PARKED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_EMPTY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_held_until_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_HELD && !release_i) |=> (state_q == ARB_HELD));
endmodule

// File: rtl/park_grant_reg.sv
module park_grant_reg #(
  parameter int unsigned N_MASTERS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 pick_valid_i,
  input  logic [IDX_W-1:0]     pick_idx_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [IDX_W-1:0]     owner_o
);
  logic [IDX_W-1:0]     owner_q, owner_d;
  logic [N_MASTERS-1:0] grant_q, grant_d;

  assign owner_d = (load_i && pick_valid_i) ? pick_idx_i : owner_q;

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
    assign grant_d[g] = load_i ? (owner_d == IDX_W'(g)) : grant_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      grant_q <= '0;
    end else begin
      owner_q <= owner_d;
      grant_q <= grant_d;
    end
  end

  assign grant_o = grant_q;
  assign owner_o = owner_q;

  assert_owner_matches_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_q != '0) |-> grant_q[owner_q]);
endmodule

// File: rtl/park_bus_arbiter.sv
module park_bus_arbiter
  import park_arb_pkg::*;
#(
  parameter  int unsigned N_MASTERS = 4,
  localparam int unsigned IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 release_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [IDX_W-1:0]     owner_o
);
  logic             load;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx;
  arb_state_e       state;

  park_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) pick_i (
    .req_i   (req_i),
    .last_i  (owner_o),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  park_tenure_ctl ctl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_req_i (|req_i),
    .release_i (release_i),
    .load_o    (load),
    .state_o   (state)
  );

  park_grant_reg #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) greg_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .pick_valid_i (pick_valid),
    .pick_idx_i   (pick_idx),
    .grant_o      (grant_o),
    .owner_o      (owner_o)
  );

  assert_grant_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_tenure_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ARB_HELD && !release_i) |=> $stable(grant_o));

  assert_grant_to_requester_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state != ARB_HELD || release_i) && (req_i != '0)) |=> ((grant_o & $past(req_i)) != '0));

  assert_park_keeps_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ARB_EMPTY && req_i == '0) |=> $stable(grant_o));
endmodule

// File: tb/park_bus_arbiter_tb_top.sv
module park_bus_arbiter_tb_top;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         rel = 1'b0;
  logic [N-1:0] grant;
  logic [W-1:0] owner;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mg;
  int           mo;
  bit           mb;

  always #10 clk = ~clk;

  park_bus_arbiter #(.N_MASTERS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .release_i(rel),
    .grant_o(grant), .owner_o(owner)
  );

  task automatic check(input string tag, input logic [N-1:0] eg, input int eo);
    checks++;
    if (grant !== eg || int'(owner) != eo) begin
      errors++;
      $display("FAIL %s grant=%b owner=%0d expected grant=%b owner=%0d", tag, grant, owner, eg, eo);
    end
  endtask

  // requirement model: rotation from previous owner + 1, tenure until release
  task automatic model_step(input logic [N-1:0] r, input bit rl);
    if (!mb || rl) begin
      if (r != '0) begin
        int p;
        p = mo;
        for (int k = N; k >= 1; k--) if (r[(mo + k) % N]) p = (mo + k) % N;
        mo = p;
        mb = 1'b1;
      end else mb = 1'b0;
      mg = '0;
      mg[mo] = 1'b1;
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input bit rl);
    req = r;
    rel = rl;
    model_step(r, rl);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    rel = 1'b0;
    mg = '0; mo = 0; mb = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 in reset", '0, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    check("R1 after reset", '0, 0);
    cyc(4'b0000, 0); check("R7 park on master 0", 4'b0001, 0);
    cyc(4'b0100, 0); check("R3 first grant", 4'b0100, 2);
    cyc(4'b1011, 0); check("R4 tenure held", 4'b0100, 2);
    cyc(4'b1011, 0); check("R4 tenure held again", 4'b0100, 2);
    cyc(4'b1011, 1); check("R5 release rotates", 4'b1000, 3);
    cyc(4'b0000, 1); check("R5 release no req parks", 4'b1000, 3);
    cyc(4'b0000, 0); check("R5 stays parked", 4'b1000, 3);
    cyc(4'b0010, 0); check("R6 parked taken over", 4'b0010, 1);
    cyc(4'b0000, 1); check("R5 parked on 1", 4'b0010, 1);
    cyc(4'b0010, 0); check("R9 parked owner reacquires", 4'b0010, 1);
    cyc(4'b0101, 0); check("R9 tenure protected", 4'b0010, 1);
    cyc(4'b1111, 1); check("R8 rotate to 2", 4'b0100, 2);
    cyc(4'b1111, 1); check("R8 rotate to 3", 4'b1000, 3);
    cyc(4'b1111, 1); check("R8 wrap to 0", 4'b0001, 0);
    cyc(4'b1111, 1); check("R8 rotate to 1", 4'b0010, 1);
    cyc(4'b0001, 1); check("R3 wrap search", 4'b0001, 0);

    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] & lfsr[7:4], lfsr[9] & lfsr[8]);
      check("R3 sweep vs model", mg, mo);
      checks++;
      if ($countones(grant) > 1) begin
        errors++;
        $display("FAIL R2 grant=%b expected at most one bit", grant);
      end
    end

    do_reset();
    check("R1 second reset", '0, 0);
    cyc(4'b1000, 0); check("R3 after reset from 0", 4'b1000, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule